// File: doc/BRIEF.md
# Two-Level Virtual Address Translator

This block turns a 32-bit virtual address into a physical address. It looks first in a small fully associative translation cache. On a miss it walks a two-level table that lives in ordinary memory. The walk reads one directory word and then one leaf word through a single read port that has a one-cycle latency. After the walk it writes the leaf word back through a write port, so that the access history in memory stays correct. Each request carries three things: the address, a store flag and a user/kernel mode flag. The block answers with a single-cycle response that holds either a physical address or a fault.

A base register holds the page-aligned physical address of the active directory, and writing it selects a new address space. Every entry, directory or leaf, is one 32-bit word laid out as follows:

- bits 31:12 hold a frame number;
- bit 0 is the valid flag;
- bit 1 allows stores;
- bit 2 allows user-mode access;
- bit 5 records that the page was referenced;
- bit 6 records that it was written.

Software clears the reference and dirty bits; the block only ever sets them. Only one request is in flight at a time.

Top module: `vm_xlate`

## Requirements
- R1: After reset the block is idle with `reqReady` high, and `respValid`, `memRdEn` and `memWrEn` low. The translation cache holds no valid entry.
- R2: A walk reads the directory word at base + 4 × va[31:22]. It then reads the leaf word at (directory frame × 4096) + 4 × va[21:12]. Read data is taken in the cycle after `memRdEn`, and two reads never occur in consecutive cycles.
- R3: A successful translation returns the leaf frame number (bits 31:12) joined with the unchanged va[11:0], with `respFault` low.
- R4: A directory or leaf word whose bit 0 is clear produces a fault response.
- R5: A store to a page whose bit 1 is clear faults. A user-mode access to a page whose bit 2 is clear faults. A kernel-mode access ignores bit 2. Every fault response carries a physical address of zero.
- R6: After a successful walk the leaf word is written back with bit 5 set, with bit 6 set for a store, and with all other bits unchanged. A faulting walk writes nothing and loads nothing into the cache.
- R7: A cache hit that needs no memory update answers from the cached translation, even if the leaf word in memory has changed since.
- R8: A store that hits a cached page whose cached dirty flag is clear walks the table again, so that bit 6 becomes set in memory.
- R9: Writing the base register switches to the address space of the new directory and invalidates every cache entry.
- R10: The cache holds `TLB_DEPTH` entries. New pages replace slots in round-robin order, starting from slot 0 after a reset or a flush. A refill of a page that is already cached reuses its slot, so no page is held twice.
- R11: Each accepted request yields exactly one `respValid` pulse of one cycle. `reqReady` is high only while the block is idle and no base write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block accepts a request this cycle |
| reqVaddr | input | 32 | Virtual address |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqUser | input | 1 | 1 = user mode, 0 = kernel mode |
| baseWrEn | input | 1 | Load the directory base and flush the cache |
| baseWrData | input | 32 | Page-aligned directory address |
| memRdEn | output | 1 | Memory read strobe |
| memRdAddr | output | 32 | Byte address of the word read |
| memRdData | input | 32 | Read word, valid the cycle after the strobe |
| memWrEn | output | 1 | Leaf write-back strobe |
| memWrAddr | output | 32 | Byte address of the word written |
| memWrData | output | 32 | Updated leaf word |
| respValid | output | 1 | Response pulse |
| respPaddr | output | 32 | Physical address, zero on a fault |
| respFault | output | 1 | Translation faulted |

## Verification
The bench keeps the default 12-bit offset, which gives 10-bit table indices. It builds the block with `TLB_DEPTH` set to 4, so the fifth distinct page already wraps the round-robin pointer. That makes the eviction of the oldest slot, and the survival of the younger slots, observable with a handful of requests. The bench also points the base register at a second directory and then back again, so that a flush is visible as a changed translation.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  localparam int PTE_W = 32;
  localparam int BIT_V = 0;
  localparam int BIT_W = 1;
  localparam int BIT_U = 2;
  localparam int BIT_R = 5;
  localparam int BIT_D = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WAIT,
    ST_LEAF_RD,
    ST_LEAF_WAIT,
    ST_RESP
  } walk_state_e;

  typedef struct packed {
    logic latchReq;
    logic resHit;
    logic rdDir;
    logic latchDir;
    logic rdLeaf;
    logic resWalk;
    logic resFault;
    logic fillTlb;
    logic wrLeaf;
  } walk_strobe_t;

  typedef struct packed {
    logic tlbHit;
    logic hitPermOk;
    logic hitNeedsDirty;
    logic dirValid;
    logic leafOk;
    logic leafNeedsWb;
  } walk_status_t;

  function automatic logic accessOk(input logic canWrite, input logic canUser,
                                    input logic isWrite, input logic isUser);
    return !(isWrite && !canWrite) && !(isUser && !canUser);
  endfunction

endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int DEPTH = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic [VPN_W-1:0] probeVpn,
  input  logic             fillEn,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PFN_W-1:0] fillPfn,
  input  logic             fillW,
  input  logic             fillU,
  input  logic             fillD,
  output logic             hitAny,
  output logic [PFN_W-1:0] hitPfn,
  output logic             hitW,
  output logic             hitU,
  output logic             hitD,
  output logic [DEPTH-1:0] hitVec
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] validArr;
  logic [VPN_W-1:0] vpnArr [DEPTH];
  logic [PFN_W-1:0] pfnArr [DEPTH];
  logic [DEPTH-1:0] wArr, uArr, dArr;
  logic [DEPTH-1:0] fillVec;
  logic [PTR_W-1:0] rrPtr, fillSlot;
  logic             fillFound;

  for (genvar g = 0; g < DEPTH; g++) begin : gCompare
    assign hitVec[g]  = validArr[g] && (vpnArr[g] == probeVpn);
    assign fillVec[g] = validArr[g] && (vpnArr[g] == fillVpn);
  end

  assign hitAny = |hitVec;

  always_comb begin
    hitPfn = '0;
    hitW   = 1'b0;
    hitU   = 1'b0;
    hitD   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hitVec[i]) begin
        hitPfn = hitPfn | pfnArr[i];
        hitW   = hitW | wArr[i];
        hitU   = hitU | uArr[i];
        hitD   = hitD | dArr[i];
      end
    end
  end

  // A page already present is refilled in place; otherwise the pointer slot.
  always_comb begin
    fillSlot  = rrPtr;
    fillFound = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (fillVec[i]) begin
        fillSlot  = PTR_W'(i);
        fillFound = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr <= '0;
      rrPtr    <= '0;
    end else if (flush) begin
      validArr <= '0;
      rrPtr    <= '0;
    end else if (fillEn) begin
      validArr[fillSlot] <= 1'b1;
      if (!fillFound) begin
        if (rrPtr == PTR_W'(DEPTH - 1)) rrPtr <= '0;
        else                            rrPtr <= rrPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fillEn && !flush) begin
      vpnArr[fillSlot] <= fillVpn;
      pfnArr[fillSlot] <= fillPfn;
      wArr[fillSlot]   <= fillW;
      uArr[fillSlot]   <= fillU;
      dArr[fillSlot]   <= fillD;
    end
  end

endmodule

// File: rtl/xlate_datapath.sv
module xlate_datapath
  import xlate_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int TLB_DEPTH = 8,
  localparam int IDX_W    = OFF_W - 2,
  localparam int VPN_W    = 2 * IDX_W,
  localparam int VA_W     = VPN_W + OFF_W,
  localparam int PFN_W    = PTE_W - OFF_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  walk_strobe_t         stb,
  output walk_status_t         status,
  input  logic [VA_W-1:0]      reqVaddr,
  input  logic                 reqWrite,
  input  logic                 reqUser,
  input  logic                 baseWrEn,
  input  logic [PTE_W-1:0]     baseWrData,
  output logic                 memRdEn,
  output logic [PTE_W-1:0]     memRdAddr,
  input  logic [PTE_W-1:0]     memRdData,
  output logic                 memWrEn,
  output logic [PTE_W-1:0]     memWrAddr,
  output logic [PTE_W-1:0]     memWrData,
  output logic [PTE_W-1:0]     respPaddr,
  output logic                 respFault,
  output logic [TLB_DEPTH-1:0] tlbHitVec
);

  logic [PFN_W-1:0] baseFrame, tblFrame;
  logic [VA_W-1:0]  vaReg;
  logic             wrReg, usrReg;
  logic [PTE_W-1:0] dirAddr, leafAddr, leafUpd;
  logic             hitAny, hitW, hitU, hitD;
  logic [PFN_W-1:0] hitPfn;
  logic             unusedBaseLow;

  assign unusedBaseLow = ^baseWrData[OFF_W-1:0];

  xlate_tlb #(
    .DEPTH(TLB_DEPTH),
    .VPN_W(VPN_W),
    .PFN_W(PFN_W)
  ) u_tlb (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (baseWrEn),
    .probeVpn (reqVaddr[VA_W-1:OFF_W]),
    .fillEn   (stb.fillTlb),
    .fillVpn  (vaReg[VA_W-1:OFF_W]),
    .fillPfn  (memRdData[PTE_W-1:OFF_W]),
    .fillW    (memRdData[BIT_W]),
    .fillU    (memRdData[BIT_U]),
    .fillD    (leafUpd[BIT_D]),
    .hitAny   (hitAny),
    .hitPfn   (hitPfn),
    .hitW     (hitW),
    .hitU     (hitU),
    .hitD     (hitD),
    .hitVec   (tlbHitVec)
  );

  assign dirAddr  = {baseFrame, vaReg[VA_W-1 -: IDX_W], 2'b00};
  assign leafAddr = {tblFrame, vaReg[OFF_W +: IDX_W], 2'b00};

  always_comb begin
    leafUpd        = memRdData;
    leafUpd[BIT_R] = 1'b1;
    if (wrReg) leafUpd[BIT_D] = 1'b1;
  end

  assign status.tlbHit        = hitAny;
  assign status.hitPermOk     = accessOk(hitW, hitU, reqWrite, reqUser);
  assign status.hitNeedsDirty = reqWrite && !hitD;
  assign status.dirValid      = memRdData[BIT_V];
  assign status.leafOk        = memRdData[BIT_V] &&
                                accessOk(memRdData[BIT_W], memRdData[BIT_U], wrReg, usrReg);
  assign status.leafNeedsWb   = !memRdData[BIT_R] || (wrReg && !memRdData[BIT_D]);

  assign memRdEn   = stb.rdDir || stb.rdLeaf;
  assign memRdAddr = stb.rdLeaf ? leafAddr : dirAddr;
  assign memWrEn   = stb.wrLeaf;
  assign memWrAddr = leafAddr;
  assign memWrData = leafUpd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseFrame <= '0;
      tblFrame  <= '0;
      vaReg     <= '0;
      wrReg     <= 1'b0;
      usrReg    <= 1'b0;
      respPaddr <= '0;
      respFault <= 1'b0;
    end else begin
      if (baseWrEn) baseFrame <= baseWrData[PTE_W-1:OFF_W];
      if (stb.latchReq) begin
        vaReg  <= reqVaddr;
        wrReg  <= reqWrite;
        usrReg <= reqUser;
      end
      if (stb.latchDir) tblFrame <= memRdData[PTE_W-1:OFF_W];
      if (stb.resHit) begin
        respFault <= !status.hitPermOk;
        respPaddr <= status.hitPermOk ? {hitPfn, reqVaddr[OFF_W-1:0]} : '0;
      end else if (stb.resWalk) begin
        respFault <= 1'b0;
        respPaddr <= {memRdData[PTE_W-1:OFF_W], vaReg[OFF_W-1:0]};
      end else if (stb.resFault) begin
        respFault <= 1'b1;
        respPaddr <= '0;
      end
    end
  end

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         baseWrEn,
  input  walk_status_t status,
  output walk_strobe_t stb,
  output logic         reqReady,
  output logic         respValid
);

  walk_state_e state, nextState;
  logic        accept;

  assign reqReady  = (state == ST_IDLE) && !baseWrEn;
  assign accept    = reqValid && reqReady;
  assign respValid = (state == ST_RESP);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          stb.latchReq = 1'b1;
          if (status.tlbHit && (!status.hitPermOk || !status.hitNeedsDirty)) begin
            stb.resHit = 1'b1;
            nextState  = ST_RESP;
          end else begin
            nextState  = ST_DIR_RD;
          end
        end
      end
      ST_DIR_RD: begin
        stb.rdDir = 1'b1;
        nextState = ST_DIR_WAIT;
      end
      ST_DIR_WAIT: begin
        if (status.dirValid) begin
          stb.latchDir = 1'b1;
          nextState    = ST_LEAF_RD;
        end else begin
          stb.resFault = 1'b1;
          nextState    = ST_RESP;
        end
      end
      ST_LEAF_RD: begin
        stb.rdLeaf = 1'b1;
        nextState  = ST_LEAF_WAIT;
      end
      ST_LEAF_WAIT: begin
        if (status.leafOk) begin
          stb.resWalk = 1'b1;
          stb.fillTlb = 1'b1;
          stb.wrLeaf  = status.leafNeedsWb;
        end else begin
          stb.resFault = 1'b1;
        end
        nextState = ST_RESP;
      end
      ST_RESP:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/vm_xlate.sv
module vm_xlate
  import xlate_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int TLB_DEPTH = 8,
  localparam int VA_W     = 3 * OFF_W - 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqWrite,
  input  logic             reqUser,
  input  logic             baseWrEn,
  input  logic [PTE_W-1:0] baseWrData,
  output logic             memRdEn,
  output logic [PTE_W-1:0] memRdAddr,
  input  logic [PTE_W-1:0] memRdData,
  output logic             memWrEn,
  output logic [PTE_W-1:0] memWrAddr,
  output logic [PTE_W-1:0] memWrData,
  output logic             respValid,
  output logic [PTE_W-1:0] respPaddr,
  output logic             respFault
);

  walk_strobe_t         stb;
  walk_status_t         status;
  logic [TLB_DEPTH-1:0] tlbHitVec;

  xlate_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .baseWrEn  (baseWrEn),
    .status    (status),
    .stb       (stb),
    .reqReady  (reqReady),
    .respValid (respValid)
  );

  xlate_datapath #(
    .OFF_W     (OFF_W),
    .TLB_DEPTH (TLB_DEPTH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .status     (status),
    .reqVaddr   (reqVaddr),
    .reqWrite   (reqWrite),
    .reqUser    (reqUser),
    .baseWrEn   (baseWrEn),
    .baseWrData (baseWrData),
    .memRdEn    (memRdEn),
    .memRdAddr  (memRdAddr),
    .memRdData  (memRdData),
    .memWrEn    (memWrEn),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData),
    .respPaddr  (respPaddr),
    .respFault  (respFault),
    .tlbHitVec  (tlbHitVec)
  );

endmodule

// File: rtl/vm_xlate_checker.sv
module vm_xlate_checker
  import xlate_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int TLB_DEPTH = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqReady,
  input logic                 baseWrEn,
  input logic                 memRdEn,
  input logic [PTE_W-1:0]     memRdData,
  input logic                 memWrEn,
  input logic [PTE_W-1:0]     memWrData,
  input logic                 respValid,
  input logic                 respFault,
  input logic [PTE_W-1:0]     respPaddr,
  input logic [TLB_DEPTH-1:0] tlbHitVec
);

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid); // R11

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || memWrEn || respValid) |-> !reqReady); // R11

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFault) |-> (respPaddr == '0)); // R5

  AST_WB_KEEPS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memWrData[PTE_W-1:OFF_W] == memRdData[PTE_W-1:OFF_W]) &&
                memWrData[BIT_R] && memWrData[BIT_V]); // R6

  AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn); // R2

  AST_TLB_UNIQUE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tlbHitVec)); // R10

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |=> (tlbHitVec == '0)); // R9

endmodule

bind vm_xlate vm_xlate_checker #(
  .OFF_W     (OFF_W),
  .TLB_DEPTH (TLB_DEPTH)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .baseWrEn  (baseWrEn),
  .memRdEn   (memRdEn),
  .memRdData (memRdData),
  .memWrEn   (memWrEn),
  .memWrData (memWrData),
  .respValid (respValid),
  .respFault (respFault),
  .respPaddr (respPaddr),
  .tlbHitVec (tlbHitVec)
);

// File: tb/vm_xlate_tb.sv
`timescale 1ns/1ps
module vm_xlate_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        memRdEn;
  logic [31:0] memRdAddr;
  logic [31:0] memRdData;
  logic        memWrEn;
  logic [31:0] memWrAddr;
  logic [31:0] memWrData;
  logic        respValid;
  logic [31:0] respPaddr;
  logic        respFault;

  logic        tbWrEn = 1'b0;
  logic [31:0] tbWrAddr = '0;
  logic [31:0] tbWrData = '0;
  logic [31:0] mem [0:4095];

  int          checks = 0;
  int          errors = 0;
  int          reqCount = 0;
  int          respCount = 0;
  logic [32:0] expQ [$];
  string       tagQ [$];

  always #2.5 clk = ~clk;

  vm_xlate #(.TLB_DEPTH(4)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .reqUser(reqUser),
    .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .respValid(respValid), .respPaddr(respPaddr), .respFault(respFault)
  );

  // Memory model: one-cycle read latency, plus a bench-side write port.
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4096; i++) mem[i] <= '0;
      memRdData <= '0;
    end else begin
      if (memRdEn) memRdData <= mem[memRdAddr[13:2]];
      if (memWrEn) mem[memWrAddr[13:2]] <= memWrData;
      if (tbWrEn)  mem[tbWrAddr[13:2]] <= tbWrData;
    end
  end

  function automatic logic [31:0] pte(input logic [19:0] frame, input logic w, input logic u);
    return {frame, 9'd0, u, w, 1'b1};
  endfunction

  function automatic logic [31:0] vaOf(input int page, input logic [11:0] off);
    return {10'd0, 10'(page), off};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && respValid) begin
      respCount++;
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R11 unexpected response actual=%h expected=none", {respFault, respPaddr});
      end else begin
        logic [32:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, {31'd0, respFault, respPaddr}, {31'd0, e});
      end
    end
  end

  task automatic poke(input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    tbWrEn = 1'b1; tbWrAddr = addr; tbWrData = data;
    @(negedge clk);
    tbWrEn = 1'b0;
  endtask

  task automatic setBase(input logic [31:0] addr);
    @(negedge clk);
    baseWrEn = 1'b1; baseWrData = addr;
    @(negedge clk);
    baseWrEn = 1'b0;
  endtask

  task automatic xreq(input logic [31:0] va, input logic wr, input logic usr,
                      input logic expFault, input logic [31:0] expPa, input string tag);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    expQ.push_back({expFault, expPa});
    tagQ.push_back(tag);
    reqCount++;
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr; reqUser = usr;
    @(negedge clk);
    reqValid = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 respValid", {63'd0, respValid}, 64'd0);
    chk("R1 reqReady", {63'd0, reqReady}, 64'd1);
    chk("R1 memRdEn", {63'd0, memRdEn}, 64'd0);
    chk("R1 memWrEn", {63'd0, memWrEn}, 64'd0);

    // Space A: directory page 1, table page 2. Space B: directory page 3, table page 0.
    poke(32'h1000, pte(20'd2, 1'b0, 1'b0));
    poke(32'h2000 + 4*1, pte(20'h101, 1'b1, 1'b1));
    poke(32'h2000 + 4*2, pte(20'h102, 1'b0, 1'b1));
    poke(32'h2000 + 4*3, pte(20'h103, 1'b1, 1'b0));
    for (int n = 5; n <= 9; n++) poke(32'h2000 + 4*n, pte(20'h100 + 20'(n), 1'b1, 1'b1));
    poke(32'h3000, pte(20'd0, 1'b0, 1'b0));
    poke(32'h0000 + 4*1, pte(20'h301, 1'b1, 1'b1));
    setBase(32'h1000);

    // R2 R3: kernel load walks both levels
    xreq(vaOf(1, 12'h123), 1'b0, 1'b0, 1'b0, 32'h0010_1123, "R3 walk load page1");
    // R6: reference set, dirty clear
    chk("R6 ref set on load", {58'd0, mem[(32'h2000 + 4)>>2][6:5]}, 64'd1);

    // R8: store hit with clean cached entry re-walks and sets dirty
    xreq(vaOf(1, 12'h456), 1'b1, 1'b0, 1'b0, 32'h0010_1456, "R8 store page1");
    chk("R8 dirty set in memory", {58'd0, mem[(32'h2000 + 4)>>2][6:5]}, 64'd3);

    // R7: cached translation used even though memory changed
    poke(32'h2000 + 4*1, pte(20'h201, 1'b1, 1'b1) | 32'h60);
    xreq(vaOf(1, 12'h789), 1'b0, 1'b0, 1'b0, 32'h0010_1789, "R7 hit ignores memory");

    // R5 R6: store to read-only page faults, nothing written back
    xreq(vaOf(2, 12'h010), 1'b1, 1'b0, 1'b1, 32'h0, "R5 store read-only");
    chk("R6 fault leaves leaf", {32'd0, mem[(32'h2000 + 8)>>2]}, {32'd0, pte(20'h102, 1'b0, 1'b1)});
    xreq(vaOf(2, 12'h020), 1'b0, 1'b1, 1'b0, 32'h0010_2020, "R5 user load user page");
    xreq(vaOf(2, 12'h030), 1'b1, 1'b0, 1'b1, 32'h0, "R5 store read-only cached");
    xreq(vaOf(3, 12'h040), 1'b0, 1'b1, 1'b1, 32'h0, "R5 user on kernel page");
    chk("R6 user fault no ref", {32'd0, mem[(32'h2000 + 12)>>2]}, {32'd0, pte(20'h103, 1'b1, 1'b0)});
    xreq(vaOf(3, 12'h050), 1'b1, 1'b0, 1'b0, 32'h0010_3050, "R5 kernel store kernel page");

    // R4: invalid leaf and invalid directory word
    xreq(vaOf(4, 12'h060), 1'b0, 1'b0, 1'b1, 32'h0, "R4 invalid leaf");
    xreq(32'h0040_1070, 1'b0, 1'b0, 1'b1, 32'h0, "R4 invalid directory");

    // R9: base switch selects other space and flushes
    setBase(32'h3000);
    xreq(vaOf(1, 12'h080), 1'b0, 1'b0, 1'b0, 32'h0030_1080, "R9 second space");
    setBase(32'h1000);
    xreq(vaOf(1, 12'h090), 1'b0, 1'b0, 1'b0, 32'h0020_1090, "R9 flush refetches");

    // R10: round-robin eviction with 4 slots
    setBase(32'h1000);
    for (int n = 5; n <= 9; n++)
      xreq(vaOf(n, 12'h0A0), 1'b0, 1'b0, 1'b0, {12'h001, 8'(n), 12'h0A0}, "R10 fill");
    poke(32'h2000 + 4*5, pte(20'h405, 1'b1, 1'b1));
    poke(32'h2000 + 4*6, pte(20'h406, 1'b1, 1'b1));
    xreq(vaOf(6, 12'h0B0), 1'b0, 1'b0, 1'b0, 32'h0010_60B0, "R10 younger slot kept");
    xreq(vaOf(5, 12'h0C0), 1'b0, 1'b0, 1'b0, 32'h0040_50C0, "R10 oldest slot evicted");

    chk("R11 one response per request", 64'(respCount), 64'(reqCount));
  endtask

  initial begin
    fork
      run();
      begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule